// File: doc/BRIEF.md
# Two-Level Pad Function Multiplexer

This block holds the function, pull and drive settings for a bank of general-purpose pads and turns them into one resolved function index per pad. Each pad owns two configuration words. The first-level word carries a 4-bit function select, a 2-bit pull code and a 2-bit drive code. When its function select holds the hand-down value, the pad takes its function from its second-level word instead. The second-level space also holds two 3-bit source selects, one for each MDIO management channel.

Each of the two register spaces has its own write-protect register. To open a space, software writes that protect register's own bus address to it with bit 0 clear. Writing the same address with bit 0 set closes the space again. While a space is closed, configuration writes to it are dropped and a sticky error flag is raised. Reads are always allowed and return through a registered 32-bit read port.

The per-pad outputs are registered. They drive the pad cells and the peripheral routing, which are both outside this block.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, both spaces are closed and every first-level word reads 0x0000000E (function 14, pull 0, drive 0). Every second-level word, both MDIO selects and `wr_err` are 0. Every pad reports function 127, pull 0 and drive 0.
- R2: Writing the protect register's byte address (space base + 0x400) to itself with bit 0 clear opens that space. Writing the same value with bit 0 set closes it. A read of the protect register returns 1 in bit 0 while the space is closed.
- R3: A write to a protect register whose data bits 31:1 differ from that register's address leaves the protection state unchanged.
- R4: A write to a pad word or MDIO select in a closed space does not change the register. It sets `wr_err`, and `wr_err` stays set until reset.
- R5: A first-level word at base + 4·pad keeps only bits 3:0 (function), 9:8 (pull: 0 none, 1 up, 3 down) and 11:10 (drive: 0..3 for 4/6/8/12 mA). All other bits read as 0. A pad's pull and drive outputs equal the stored codes.
- R6: The resolved function is chosen from the first-level select as follows:
  - 0..9 gives the same value.
  - 15 gives 10 plus the second-level code.
  - 10..14 give 127 (high-impedance).
- R7: A second-level word keeps bits 5:0 and reads them back as written. A stored code above 61 resolves to 127.
- R8: The MDIO channel 0 and channel 1 selects are at level-2 offsets 0x404 and 0x408. Each keeps bits 2:0, which read back and appear on `mdio_src` (channel 0 in bits 2:0).
- R9: Pad outputs change one clock after the register write that affects them, never in the same edge as the write.
- R10: `rdata` is registered. It shows the addressed register one clock after the address is presented. When a write hits the same register in that cycle, it shows the value from before the write.
- R11: The two spaces are protected independently. Opening one leaves the other closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Byte address of the access |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wr_err | output | 1 | Sticky flag for a write dropped by protection |
| pad_func | output | 7·NUM_PADS | Resolved function index per pad (127 = high-impedance) |
| pad_pull | output | 2·NUM_PADS | Pull code per pad |
| pad_drive | output | 2·NUM_PADS | Drive code per pad |
| mdio_src | output | 6 | MDIO source selects, channel 0 in bits 2:0 |

## Verification
A read and a write can land in the same cycle on the same register, because the port has a single address. The bench provokes this by presenting a write to a first-level pad word together with a scoreboard read request. It expects the value from before the write on the next clock, and the new value on a following read. A second overlap comes from the write-to-output path. A pad write and its effect on the pad outputs are one clock apart, so the bench samples the pad outputs right after the write edge, where it expects the old function, and again one clock later, where it expects the new one.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;
  localparam int          FUNC_W       = 7;
  localparam int          L2_W         = 6;
  localparam int          MDIO_W       = 3;
  localparam int          NUM_MDIO     = 2;
  localparam int          L1_DIRECT_MAX = 9;
  localparam int          L2_MAX       = 61;
  localparam logic [3:0]  L1_DEFER     = 4'hF;
  localparam logic [3:0]  L1_RST_FUNC  = 4'hE;
  localparam logic [FUNC_W-1:0] FUNC_HIZ = 7'd127;
  localparam int          L2_FUNC_OFS  = 10;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] func;
  } l1_cfg_t;

  // Merge both levels into one function index.
  function automatic logic [FUNC_W-1:0] resolve(input logic [3:0] f1,
                                                 input logic [L2_W-1:0] f2);
    logic [FUNC_W-1:0] r;
    if (int'(f1) <= L1_DIRECT_MAX)
      r = FUNC_W'(f1);
    else if (f1 == L1_DEFER)
      r = (int'(f2) <= L2_MAX) ? FUNC_W'(int'(f2) + L2_FUNC_OFS) : FUNC_HIZ;
    else
      r = FUNC_HIZ;
    return r;
  endfunction
endpackage

// File: rtl/pinmux_guard.sv
`timescale 1ns/1ps
module pinmux_guard #(
  parameter logic [31:0] KEY = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_we,
  input  logic [31:0] wdata,
  output logic        open
);
  always_ff @(posedge clk) begin
    if (rst)
      open <= 1'b0;
    else if (prot_we && (wdata[31:1] == KEY[31:1]))
      open <= ~wdata[0];
  end
endmodule

// File: rtl/pinmux_regs.sv
`timescale 1ns/1ps
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int          NUM_PADS   = 170,
  parameter logic [31:0] L1_BASE    = 32'h4000_0000,
  parameter logic [31:0] L2_BASE    = 32'h4000_1000,
  parameter int          SPACE_BITS = 12,
  parameter int unsigned PROT_OFS   = 32'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       addr,
  input  logic              we,
  input  logic [11:0]       wdata,
  input  logic              l1_open,
  input  logic              l2_open,
  output logic              l1_prot_we,
  output logic              l2_prot_we,
  output l1_cfg_t           l1_cfg   [NUM_PADS],
  output logic [L2_W-1:0]   l2_cfg   [NUM_PADS],
  output logic [MDIO_W-1:0] mdio_sel [NUM_MDIO],
  output logic [31:0]       rdata,
  output logic              wr_err
);
  localparam int PAD_W = $clog2(NUM_PADS);
  localparam int IDX_W = SPACE_BITS - 2;
  localparam logic [SPACE_BITS-1:0] PROT_A = SPACE_BITS'(PROT_OFS);

  logic                  in_l1, in_l2, pad_ok;
  logic [SPACE_BITS-1:0] offs;
  logic [IDX_W-1:0]      idx;
  logic [PAD_W-1:0]      pad_idx;
  logic                  l1_pad_hit, l2_pad_hit;
  logic [NUM_MDIO-1:0]   mdio_hit;
  logic                  l1_prot_hit, l2_prot_hit;

  assign in_l1   = addr[31:SPACE_BITS] == L1_BASE[31:SPACE_BITS];
  assign in_l2   = addr[31:SPACE_BITS] == L2_BASE[31:SPACE_BITS];
  assign offs    = addr[SPACE_BITS-1:0];
  assign idx     = offs[SPACE_BITS-1:2];
  assign pad_idx = idx[PAD_W-1:0];
  assign pad_ok  = (offs[1:0] == 2'b00) && (int'(idx) < NUM_PADS) && (offs < PROT_A);

  assign l1_pad_hit  = in_l1 && pad_ok;
  assign l2_pad_hit  = in_l2 && pad_ok;
  assign l1_prot_hit = in_l1 && (offs == PROT_A);
  assign l2_prot_hit = in_l2 && (offs == PROT_A);
  assign l1_prot_we  = we && l1_prot_hit;
  assign l2_prot_we  = we && l2_prot_hit;

  for (genvar c = 0; c < NUM_MDIO; c++) begin : g_mdio_dec
    assign mdio_hit[c] = in_l2 && (offs == PROT_A + SPACE_BITS'(4 * (c + 1)));
  end

  // Configuration storage, gated by the level's protection state.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        l1_cfg[p] <= '{drive: 2'd0, pull: 2'd0, func: L1_RST_FUNC};
        l2_cfg[p] <= '0;
      end
      for (int c = 0; c < NUM_MDIO; c++) mdio_sel[c] <= '0;
    end else if (we) begin
      if (l1_pad_hit && l1_open)
        l1_cfg[pad_idx] <= '{drive: wdata[11:10], pull: wdata[9:8], func: wdata[3:0]};
      if (l2_pad_hit && l2_open)
        l2_cfg[pad_idx] <= wdata[L2_W-1:0];
      for (int c = 0; c < NUM_MDIO; c++)
        if (mdio_hit[c] && l2_open) mdio_sel[c] <= wdata[MDIO_W-1:0];
    end
  end

  // Sticky error on a dropped configuration write.
  always_ff @(posedge clk) begin
    if (rst)
      wr_err <= 1'b0;
    else if (we && ((l1_pad_hit && !l1_open) ||
                    ((l2_pad_hit || (|mdio_hit)) && !l2_open)))
      wr_err <= 1'b1;
  end

  // Registered read port; sees contents before a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (l1_pad_hit) begin
        rdata[11:10] <= l1_cfg[pad_idx].drive;
        rdata[9:8]   <= l1_cfg[pad_idx].pull;
        rdata[3:0]   <= l1_cfg[pad_idx].func;
      end else if (l2_pad_hit) begin
        rdata[L2_W-1:0] <= l2_cfg[pad_idx];
      end else if (l1_prot_hit) begin
        rdata[0] <= ~l1_open;
      end else if (l2_prot_hit) begin
        rdata[0] <= ~l2_open;
      end else begin
        for (int c = 0; c < NUM_MDIO; c++)
          if (mdio_hit[c]) rdata[MDIO_W-1:0] <= mdio_sel[c];
      end
    end
  end
endmodule

// File: rtl/pinmux_resolve.sv
`timescale 1ns/1ps
module pinmux_resolve
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 170
) (
  input  logic                       clk,
  input  logic                       rst,
  input  l1_cfg_t                    l1_cfg [NUM_PADS],
  input  logic [L2_W-1:0]            l2_cfg [NUM_PADS],
  output logic [NUM_PADS*FUNC_W-1:0] pad_func,
  output logic [NUM_PADS*2-1:0]      pad_pull,
  output logic [NUM_PADS*2-1:0]      pad_drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        pad_func[p*FUNC_W +: FUNC_W] <= FUNC_HIZ;
        pad_pull[p*2 +: 2]           <= 2'd0;
        pad_drive[p*2 +: 2]          <= 2'd0;
      end
    end else begin
      for (int p = 0; p < NUM_PADS; p++) begin
        pad_func[p*FUNC_W +: FUNC_W] <= resolve(l1_cfg[p].func, l2_cfg[p]);
        pad_pull[p*2 +: 2]           <= l1_cfg[p].pull;
        pad_drive[p*2 +: 2]          <= l1_cfg[p].drive;
      end
    end
  end
endmodule

// File: rtl/pinmux_ctrl.sv
`timescale 1ns/1ps
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int          NUM_PADS   = 170,
  parameter logic [31:0] L1_BASE    = 32'h4000_0000,
  parameter logic [31:0] L2_BASE    = 32'h4000_1000,
  parameter int          SPACE_BITS = 12,
  parameter int unsigned PROT_OFS   = 32'h400
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [31:0]                   addr,
  input  logic                          we,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic                          wr_err,
  output logic [NUM_PADS*FUNC_W-1:0]    pad_func,
  output logic [NUM_PADS*2-1:0]         pad_pull,
  output logic [NUM_PADS*2-1:0]         pad_drive,
  output logic [NUM_MDIO*MDIO_W-1:0]    mdio_src
);
  localparam logic [31:0] L1_KEY = L1_BASE + PROT_OFS;
  localparam logic [31:0] L2_KEY = L2_BASE + PROT_OFS;

  logic              l1_open, l2_open, l1_prot_we, l2_prot_we;
  l1_cfg_t           l1_cfg   [NUM_PADS];
  logic [L2_W-1:0]   l2_cfg   [NUM_PADS];
  logic [MDIO_W-1:0] mdio_sel [NUM_MDIO];

  pinmux_guard #(.KEY(L1_KEY)) u_guard_l1 (
    .clk(clk), .rst(rst), .prot_we(l1_prot_we), .wdata(wdata), .open(l1_open));
  pinmux_guard #(.KEY(L2_KEY)) u_guard_l2 (
    .clk(clk), .rst(rst), .prot_we(l2_prot_we), .wdata(wdata), .open(l2_open));

  pinmux_regs #(
    .NUM_PADS(NUM_PADS), .L1_BASE(L1_BASE), .L2_BASE(L2_BASE),
    .SPACE_BITS(SPACE_BITS), .PROT_OFS(PROT_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata[11:0]),
    .l1_open(l1_open), .l2_open(l2_open),
    .l1_prot_we(l1_prot_we), .l2_prot_we(l2_prot_we),
    .l1_cfg(l1_cfg), .l2_cfg(l2_cfg), .mdio_sel(mdio_sel),
    .rdata(rdata), .wr_err(wr_err));

  pinmux_resolve #(.NUM_PADS(NUM_PADS)) u_resolve (
    .clk(clk), .rst(rst), .l1_cfg(l1_cfg), .l2_cfg(l2_cfg),
    .pad_func(pad_func), .pad_pull(pad_pull), .pad_drive(pad_drive));

  for (genvar c = 0; c < NUM_MDIO; c++) begin : g_mdio_out
    assign mdio_src[c*MDIO_W +: MDIO_W] = mdio_sel[c];
  end
endmodule

// File: rtl/pinmux_ctrl_chk.sv
`timescale 1ns/1ps
module pinmux_ctrl_chk #(
  parameter int          NUM_PADS = 170,
  parameter logic [31:0] L1_BASE  = 32'h4000_0000,
  parameter int unsigned PROT_OFS = 32'h400
) (
  input logic                  clk,
  input logic                  rst,
  input logic [31:0]           addr,
  input logic                  we,
  input logic [31:0]           wdata,
  input logic                  wr_err,
  input logic                  l1_open,
  input logic                  l2_open,
  input logic [NUM_PADS*7-1:0] pad_func,
  input logic [5:0]            mdio_src
);
  localparam logic [31:0] KEY1 = L1_BASE + PROT_OFS;

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R4
  locked_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == L1_BASE && !l1_open) |=> wr_err);

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == KEY1 && wdata == KEY1) |=> l1_open);

  // R2
  key_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == KEY1 && wdata == (KEY1 | 32'd1)) |=> !l1_open);

  // R3
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == KEY1 && wdata[31:1] == KEY1[31:1]) |=> $stable(l1_open));

  // R11
  levels_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == KEY1) |=> $stable(l2_open));

  // R6
  func_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_func[6:0] <= 7'd71) || (pad_func[6:0] == 7'd127));

  // R8
  mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mdio_src));
endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(
  .NUM_PADS(NUM_PADS), .L1_BASE(L1_BASE), .PROT_OFS(PROT_OFS)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .wr_err(wr_err),
  .l1_open(l1_open), .l2_open(l2_open), .pad_func(pad_func), .mdio_src(mdio_src));

// File: tb/sim_pinmux_ctrl.sv
`timescale 1ns/1ps
module sim_pinmux_ctrl;
  localparam int NP = 170;
  localparam logic [31:0] P1 = 32'h4000_0400;
  localparam logic [31:0] P2 = 32'h4000_1400;
  localparam logic [31:0] M0 = 32'h4000_1404;
  localparam logic [31:0] M1 = 32'h4000_1408;

  logic        clk = 1'b0, rst = 1'b1, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  wire  [31:0] rdata;
  wire         wr_err;
  wire  [NP*7-1:0] pad_func;
  wire  [NP*2-1:0] pad_pull, pad_drive;
  wire  [5:0]      mdio_src;

  pinmux_ctrl u0 (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .wr_err(wr_err), .pad_func(pad_func), .pad_pull(pad_pull),
    .pad_drive(pad_drive), .mdio_src(mdio_src));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0, rd_req_q = 1'b0;

  function automatic logic [31:0] a1(int p); return 32'h4000_0000 + 32'(4 * p); endfunction
  function automatic logic [31:0] a2(int p); return 32'h4000_1000 + 32'(4 * p); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_req_q <= rd_req;

  // Monitor: pops one expected item per completed read.
  always @(negedge clk) begin
    if (rd_req_q) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, logic [31:0] e, string tag);
    @(negedge clk); addr = a; we = 1'b0; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic wr_rd(logic [31:0] a, logic [31:0] d, logic [31:0] old, string tag);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; rd_req = 1'b1;
    exp_q.push_back(old); tag_q.push_back(tag);
    @(negedge clk); we = 1'b0; rd_req = 1'b0;
  endtask

  function automatic logic [31:0] fn(int p); return 32'(pad_func[p*7 +: 7]); endfunction
  function automatic logic [31:0] pl(int p); return 32'(pad_pull[p*2 +: 2]); endfunction
  function automatic logic [31:0] dr(int p); return 32'(pad_drive[p*2 +: 2]); endfunction

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pad0 func", fn(0), 32'd127);
    check("R1 pad169 pull", pl(169), 0);
    check("R1 pad169 drive", dr(169), 0);
    check("R1 err", 32'(wr_err), 0);
    check("R1 mdio", 32'(mdio_src), 0);
    rd(a1(0), 32'h0000_000E, "R1 l1 word");
    rd(a2(0), 0, "R1 l2 word");
    rd(P1, 1, "R1 l1 locked");
    rd(M0, 0, "R1 mdio0");

    // R4 locked write dropped, error sticky
    wr(a1(5), 32'h0000_0D03);
    rd(a1(5), 32'h0000_000E, "R4 dropped");
    check("R4 err set", 32'(wr_err), 1);
    check("R4 pad5 unchanged", fn(5), 32'd127);

    // R3 bad keys ignored
    wr(P1, 32'h1234_0400);
    rd(P1, 1, "R3 wrong key");
    wr(P1, P2);
    rd(P1, 1, "R3 other level key");

    // R2 / R11 open level 1 only
    wr(P1, P1);
    rd(P1, 0, "R2 l1 open");
    rd(P2, 1, "R11 l2 still locked");
    wr(a2(0), 32'd5);
    rd(a2(0), 0, "R11 l2 write dropped");

    // R5 / R9 field storage and output timing
    wr(a1(5), 32'hFFFF_F3F7);
    check("R9 no change on write edge", fn(5), 32'd127);
    @(negedge clk);
    check("R9 R6 pad5 func", fn(5), 32'd7);
    check("R5 pad5 pull", pl(5), 32'd3);
    check("R5 pad5 drive", dr(5), 0);
    rd(a1(5), 32'h0000_0307, "R5 readback");

    // R6 defer to level 2
    wr(a1(169), 32'h0000_0C0F);
    @(negedge clk);
    check("R6 pad169 defer", fn(169), 32'd10);
    check("R5 pad169 drive", dr(169), 32'd3);

    // R7 level 2 range
    wr(P2, P2);
    rd(P2, 0, "R2 l2 open");
    wr(a2(169), 32'd61);
    @(negedge clk);
    check("R7 code 61", fn(169), 32'd71);
    wr(a2(169), 32'd62);
    @(negedge clk);
    check("R7 code 62 hiz", fn(169), 32'd127);
    rd(a2(169), 32'h0000_003E, "R7 readback 62");
    wr(a2(169), 32'hFFFF_FFC5);
    @(negedge clk);
    check("R7 masked code", fn(169), 32'd15);
    rd(a2(169), 32'd5, "R7 readback masked");

    // R6 reserved and top direct codes
    wr(a1(0), 32'h0000_000C);
    @(negedge clk);
    check("R6 reserved hiz", fn(0), 32'd127);
    wr(a1(0), 32'h0000_0009);
    @(negedge clk);
    check("R6 direct 9", fn(0), 32'd9);

    // R8 MDIO selects
    wr(M0, 32'd5);
    wr(M1, 32'hFFFF_FFFA);
    check("R8 mdio outputs", 32'(mdio_src), 32'({3'd2, 3'd5}));
    rd(M0, 32'd5, "R8 mdio0");
    rd(M1, 32'd2, "R8 mdio1");

    // R10 read during write
    wr_rd(a1(0), 32'h0000_0103, 32'h0000_0009, "R10 old value");
    rd(a1(0), 32'h0000_0103, "R10 new value");
    check("R5 pad0 pull up", pl(0), 32'd1);

    // R2 close level 2 again
    wr(P2, P2 | 32'd1);
    rd(P2, 1, "R2 l2 closed");
    wr(a2(169), 32'd0);
    rd(a2(169), 32'd5, "R4 l2 closed drop");
    check("R4 err still set", 32'(wr_err), 1);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule